// File: doc/BRIEF.md
# DAC Conversion Sequencer

This block drives a two-channel digital-to-analog converter macro. Conversion words come in on a valid/ready stream, each tagged with the channel select that is present when it is accepted. They wait in a four-entry queue. After the block is enabled it holds off for a programmable warm-up interval. It then launches one conversion at a time toward the analog macro. Each conversion goes to the channel its word was tagged with.

A conversion ends in one of two ways. In normal mode the block waits for the end-of-cycle strobe that the macro returns. In fast mode it ignores that strobe and uses its own cycle counter, which cuts two clocks from each conversion. A refresh timer counts in blocks of 1024 clocks. When it expires, the block converts each channel's last value again, so that a held analog level does not droop. A period of zero turns the refresh off.

The input stream follows these back-pressure rules. A word moves on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when the queue is full. A word that a source offers while `in_ready` is low is not kept. The source is expected to hold it until `in_ready` returns.

Top module: `dac_sequencer`

## Requirements
- R1: After the clock edge that first samples `enable` high from idle, with data already queued, `conv_start` first goes high S+2 edges later, where S is `startup_cycles`. It is never high during idle or warm-up.
- R2: `in_ready` is high while fewer than 4 words are queued, and low when 4 are queued. A word is accepted on an edge where `in_valid` and `in_ready` are both high.
- R3: A word offered while `in_ready` is low is discarded and never converted. It sets `overflow`, which stays set until reset.
- R4: Each accepted word carries the value of `chan_sel` (0 or 1) at acceptance. Words are issued in arrival order. During the one-cycle `conv_start` pulse, `conv_chan` and `conv_data` hold that channel and that word.
- R5: In normal mode a conversion ends on the edge that samples `conv_eoc` high. The next queued conversion starts on the following edge, so with a macro that answers in the 25th cycle, starts are 26 cycles apart.
- R6: In fast mode `conv_eoc` is ignored and a conversion lasts 23 cycles. Back-to-back starts are then 24 cycles apart, two fewer than in normal mode, even if `conv_eoc` never arrives.
- R7: `eoc_pulse` is a one-cycle pulse for each conversion. In normal mode it rises on the edge after `conv_eoc` is sampled. In fast mode it is held back by two cycles. With the 25-cycle macro, both modes raise it 25 edges after `conv_start` rose.
- R8: With a nonzero `refresh_period` P, once every P×1024 clocks the last value of each channel that has ever been converted is issued again. Channel 0 goes before channel 1. A channel that has never held data is skipped.
- R9: With `refresh_period` equal to 0, no refresh conversion is issued and no refresh is left pending.
- R10: When queued words and pending refreshes are both waiting, the queued word is converted first. The pending refresh follows it.
- R11: After reset `in_ready` is 1, and `conv_start`, `eoc_pulse` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sequencer; low returns it to idle |
| fast_mode | input | 1 | 1 = internal counter ends conversions |
| startup_cycles | input | 8 | Warm-up length in clocks |
| refresh_period | input | 4 | Refresh interval in units of 1024 clocks; 0 = off |
| chan_sel | input | 1 | Channel tagged onto words accepted from now on |
| in_valid | input | 1 | Stream word present |
| in_data | input | 12 | Stream word |
| in_ready | output | 1 | Queue can accept a word |
| overflow | output | 1 | Sticky: a word was offered while full |
| conv_start | output | 1 | One-cycle conversion launch to the macro |
| conv_chan | output | 1 | Channel of the current conversion |
| conv_data | output | 12 | Value of the current conversion |
| conv_eoc | input | 1 | End-of-cycle strobe from the macro |
| eoc_pulse | output | 1 | One-cycle conversion-complete pulse |

## Verification
Two functions can meet at one arbitration point: refresh expiry and the arrival of new queued data. The bench creates this overlap on purpose. When a channel-0 refresh start is seen, with channel 1's refresh still pending, it writes a fresh channel-0 word. That word lands in the queue while the refresh conversion is still running. The bench then checks the next two launches: the fresh word must come first and the channel-1 refresh second, each with its expected value, and they must be exactly one normal conversion interval apart.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WARM,
    SQ_ARMED,
    SQ_CONV
  } seq_state_e;
endpackage

// File: rtl/dacseq_fifo.sv
module dacseq_fifo #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign wr_ready = (count != FULL_C);
  assign rd_empty = (count == '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && !rd_empty;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == LAST_C) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST_C) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (wr_valid && !wr_ready) overflow <= 1'b1;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C); // R2
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !rd_pop) |=> !wr_ready); // R2
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overflow); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R3
endmodule

// File: rtl/dacseq_refresh.sv
module dacseq_refresh #(
  parameter int PER_W  = 4,
  parameter int UNIT   = 1024,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [PER_W-1:0]  period,
  input  logic [NUM_CH-1:0] has_data,
  input  logic [NUM_CH-1:0] grant,
  output logic [NUM_CH-1:0] pending
);
  localparam int PRE_W = (UNIT > 1) ? $clog2(UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT - 1);

  logic [PRE_W-1:0] pre;
  logic [PER_W-1:0] units;
  logic             tick, expire;

  assign tick   = (pre == PRE_LAST);
  assign expire = tick && (period != '0) && (units >= period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || period == '0) begin
      pre     <= '0;
      units   <= '0;
      pending <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) units <= expire ? '0 : units + 1'b1;
      pending <= (pending & ~grant) | (expire ? has_data : '0);
    end
  end

  AST_ZERO_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> (pending == '0)); // R9
  AST_PEND_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~has_data) == '0); // R8
endmodule

// File: rtl/dac_sequencer.sv
module dac_sequencer
  import dacseq_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int NUM_CH       = 2,
  parameter int FIFO_DEPTH   = 4,
  parameter int CONV_CYCLES  = 25,
  parameter int STARTUP_W    = 8,
  parameter int REFRESH_W    = 4,
  parameter int REFRESH_UNIT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 fast_mode,
  input  logic [STARTUP_W-1:0] startup_cycles,
  input  logic [REFRESH_W-1:0] refresh_period,
  input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] chan_sel,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 in_ready,
  output logic                 overflow,
  output logic                 conv_start,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] conv_chan,
  output logic [DATA_W-1:0]    conv_data,
  input  logic                 conv_eoc,
  output logic                 eoc_pulse
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ENT_W = CH_W + DATA_W;
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int CW    = (STARTUP_W > CNT_W) ? STARTUP_W : CNT_W;
  localparam logic [CW-1:0] FAST_LAST = CW'(CONV_CYCLES - 3);

  seq_state_e        state;
  logic [CW-1:0]     cnt;
  logic [ENT_W-1:0]  fifo_entry;
  logic              fifo_empty, load;
  logic [CH_W-1:0]   ld_ch, ref_sel;
  logic [DATA_W-1:0] last_val [NUM_CH];
  logic [NUM_CH-1:0] has_data, pending, grant;
  logic              ref_any;
  logic [1:0]        lag;

  dacseq_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_data({chan_sel, in_data}), .wr_ready(in_ready),
    .rd_pop(load), .rd_data(fifo_entry), .rd_empty(fifo_empty),
    .overflow(overflow)
  );

  dacseq_refresh #(.PER_W(REFRESH_W), .UNIT(REFRESH_UNIT), .NUM_CH(NUM_CH)) u_refresh (
    .clk(clk), .rst_n(rst_n),
    .active(state != SQ_IDLE), .period(refresh_period),
    .has_data(has_data), .grant(grant), .pending(pending)
  );

  assign load  = enable && (state == SQ_ARMED) && !fifo_empty;
  assign ld_ch = fifo_entry[ENT_W-1 -: CH_W];

  // lowest-numbered pending channel wins
  always_comb begin
    ref_any = |pending;
    ref_sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) ref_sel = CH_W'(i);
    end
  end

  assign grant = (enable && state == SQ_ARMED && fifo_empty && ref_any)
               ? (NUM_CH'(1) << ref_sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_data <= '0;
      for (int i = 0; i < NUM_CH; i++) last_val[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ld_ch == CH_W'(i)) begin
          last_val[i] <= fifo_entry[DATA_W-1:0];
          has_data[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_data  <= '0;
      lag        <= '0;
      eoc_pulse  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      lag        <= {lag[0], 1'b0};
      eoc_pulse  <= lag[1];
      if (!enable) begin
        state <= SQ_IDLE;
      end else begin
        case (state)
          SQ_IDLE: begin
            cnt   <= CW'(startup_cycles);
            state <= SQ_WARM;
          end
          SQ_WARM: begin
            if (cnt == '0) state <= SQ_ARMED;
            else           cnt   <= cnt - 1'b1;
          end
          SQ_ARMED: begin
            if (!fifo_empty) begin
              conv_start <= 1'b1;
              conv_chan  <= ld_ch;
              conv_data  <= fifo_entry[DATA_W-1:0];
              cnt        <= '0;
              state      <= SQ_CONV;
            end else if (ref_any) begin
              conv_start <= 1'b1;
              conv_chan  <= ref_sel;
              conv_data  <= last_val[ref_sel];
              cnt        <= '0;
              state      <= SQ_CONV;
            end
          end
          SQ_CONV: begin
            if (fast_mode) begin
              if (cnt == FAST_LAST) begin
                state <= SQ_ARMED;
                lag   <= {lag[0], 1'b1};
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (conv_eoc) begin
              state     <= SQ_ARMED;
              eoc_pulse <= 1'b1;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  AST_NO_START_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE || state == SQ_WARM) |-> !conv_start); // R1
  AST_EOC_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SQ_CONV && !fast_mode && conv_eoc) |=> (state == SQ_ARMED)); // R5
  AST_FAST_IGNORES_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SQ_CONV && fast_mode && cnt != FAST_LAST) |=> (state == SQ_CONV)); // R6
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |=> !eoc_pulse); // R7
  AST_QUEUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SQ_ARMED && !fifo_empty)
      |=> (conv_start && conv_data == $past(fifo_entry[DATA_W-1:0]))); // R10
endmodule

// File: tb/dac_sequencer_bench.sv
`timescale 1ns/1ps
module dac_sequencer_bench;
  localparam int CONV = 25;
  localparam int UNIT = 1024;
  // table: {channel, data}; expected output is the same pair, in order
  localparam logic [12:0] WR_TAB [0:3] = '{13'h0123, 13'h1ABC, 13'h1000, 13'h0FFF};
  localparam logic [12:0] FAST_TAB [0:2] = '{13'h1456, 13'h0789, 13'h100F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fast_mode = 1'b0;
  logic [7:0] startup_cycles = 8'd0;
  logic [3:0] refresh_period = 4'd0;
  logic chan_sel = 1'b0, in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic in_ready, overflow, conv_start, conv_eoc, eoc_pulse;
  logic conv_chan;
  logic [11:0] conv_data;

  always #10 clk = ~clk;

  dac_sequencer u_dac_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .startup_cycles(startup_cycles), .refresh_period(refresh_period),
    .chan_sel(chan_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .overflow(overflow), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_data(conv_data), .conv_eoc(conv_eoc),
    .eoc_pulse(eoc_pulse)
  );

  // analog macro stub: strobe high in the CONV-th cycle of a conversion
  logic stub_mute = 1'b0;
  int scnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      scnt <= 0;
      conv_eoc <= 1'b0;
    end else begin
      if (conv_start) scnt <= CONV - 2;
      else if (scnt != 0) scnt <= scnt - 1;
      conv_eoc <= !stub_mute && !conv_start && scnt == 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_log = 0, n_eoc = 0;
  int log_cyc [64];
  logic log_ch [64];
  logic [11:0] log_dat [64];
  int eoc_cyc [64];
  always @(negedge clk) begin
    if (conv_start && n_log < 64) begin
      log_cyc[n_log] = cyc; log_ch[n_log] = conv_chan; log_dat[n_log] = conv_data;
      n_log = n_log + 1;
    end
    if (eoc_pulse && n_eoc < 64) begin
      eoc_cyc[n_eoc] = cyc;
      n_eoc = n_eoc + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic ch, input logic [11:0] d);
    @(negedge clk);
    in_valid = 1'b1; chan_sel = ch; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c0, b, eb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready", in_ready, 1);
    chk("R11 conv_start", conv_start, 0);
    chk("R11 eoc_pulse", eoc_pulse, 0);
    chk("R11 overflow", overflow, 0);

    // fill queue while disabled, then overrun it
    for (int i = 0; i < 4; i++) push(WR_TAB[i][12], WR_TAB[i][11:0]);
    chk("R2 in_ready when full", in_ready, 0);
    push(1'b0, 12'h777);
    chk("R3 overflow set", overflow, 1);
    chk("R2 still full after drop", in_ready, 0);

    // normal-mode run with warm-up 5
    startup_cycles = 8'd5;
    b = n_log; eb = n_eoc;
    @(negedge clk); c0 = cyc; enable = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 dropped word not converted", n_log - b, 4);
    chk("R1 first start delay", log_cyc[b] - c0, 5 + 3);
    for (int i = 0; i < 4; i++) begin
      chk("R4 channel", log_ch[b+i], WR_TAB[i][12]);
      chk("R4 data", log_dat[b+i], WR_TAB[i][11:0]);
      chk("R7 eoc timing normal", eoc_cyc[eb+i] - log_cyc[b+i], CONV);
      if (i > 0) chk("R5 normal spacing", log_cyc[b+i] - log_cyc[b+i-1], CONV + 1);
    end
    chk("R3 overflow sticky", overflow, 1);

    // fast mode with the macro strobe silenced
    @(negedge clk); fast_mode = 1'b1; stub_mute = 1'b1;
    b = n_log; eb = n_eoc;
    for (int i = 0; i < 3; i++) push(FAST_TAB[i][12], FAST_TAB[i][11:0]);
    repeat (150) @(negedge clk);
    chk("R6 fast count", n_log - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 fast channel", log_ch[b+i], FAST_TAB[i][12]);
      chk("R4 fast data", log_dat[b+i], FAST_TAB[i][11:0]);
      chk("R7 eoc timing fast", eoc_cyc[eb+i] - log_cyc[b+i], CONV);
      if (i > 0) chk("R6 fast spacing", log_cyc[b+i] - log_cyc[b+i-1], CONV - 1);
    end
    fast_mode = 1'b0; stub_mute = 1'b0;

    // refresh: only channel 0 holds data
    enable = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; startup_cycles = 8'd0; refresh_period = 4'd2;
    push(1'b0, 12'h3A5);
    b = n_log;
    @(negedge clk); enable = 1'b1;
    repeat (7000) @(negedge clk);
    chk("R8 refresh count", n_log - b, 4);
    for (int k = 1; k < 4; k++) begin
      chk("R8 refresh channel 0 only", log_ch[b+k], 0);
      chk("R8 refresh value", log_dat[b+k], 12'h3A5);
      if (k > 1) chk("R8 refresh period", log_cyc[b+k] - log_cyc[b+k-1], 2 * UNIT);
    end

    // queued data against a pending refresh
    b = n_log;
    push(1'b1, 12'h155);
    while (n_log < b + 2) @(negedge clk);
    chk("R8 refresh ch0 seen", log_ch[b+1], 0);
    push(1'b0, 12'h0F0);
    while (n_log < b + 4) @(negedge clk);
    chk("R10 queued word first ch", log_ch[b+2], 0);
    chk("R10 queued word first data", log_dat[b+2], 12'h0F0);
    chk("R10 refresh ch1 after", log_ch[b+3], 1);
    chk("R10 refresh ch1 value", log_dat[b+3], 12'h155);
    chk("R10 back-to-back", log_cyc[b+3] - log_cyc[b+2], CONV + 1);

    // zero period disables refresh
    repeat (100) @(negedge clk);
    refresh_period = 4'd0;
    b = n_log;
    repeat (5000) @(negedge clk);
    chk("R9 no refresh at period 0", n_log - b, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule